// File: doc/BRIEF.md
# CPU Core Clock Ratio Generator

This block derives the CPU core clock from two clocks: a fast PLL clock, which also clocks all of the block's logic, and a slower crystal reference clock. Software sets up the path through two control words on a small register port. A source select chooses whether the divider counts PLL cycles or crystal rising edges. A two-bit ratio code chooses divide-by-1, 2 or 3, or, with its top code, divide-by-2N, where N comes from a 9-bit field in the second word. An output select chooses between the divided path and the crystal clock passed straight through.

The divided clock is represented in the PLL domain. `cpuEn` is a one-cycle enable pulse that marks the end of each output period. `cpuClk` is a registered level that is high for the first half of each period. The crystal input is synchronised into the PLL domain before anything uses it. A new ratio is held back until the current output period ends, so no shortened period appears on the output.

Top module: `cpu_clk_divider`

## Requirements
- R1: After reset both control words read as zero. This selects the crystal as divider source, ratio code 0, and the crystal pass-through output. `cpuEn` then pulses once per crystal period.
- R2: The main control word is at address 0x40. Bit 0 is the source select, bits [3:2] the ratio code and bit 7 the output select. A read returns the last written value of these bits, and all other bits read as zero.
- R3: The auxiliary word is at address 0x00 and holds N in bits [28:20]. Its other bits, and every other address, read as zero. A write to any other address changes no stored field.
- R4: Ratio codes 0, 1 and 2 give one output period every 1, 2 and 3 source ticks.
- R5: Ratio code 3 with N from 1 to 511 gives one output period every 2*N source ticks.
- R6: Ratio code 3 with N equal to 0 gives divide-by-1. The output is never stopped.
- R7: With source select 1 every PLL cycle is a source tick. With source select 0 each crystal rising edge is one source tick.
- R8: With output select 0, `cpuEn` pulses once per crystal rising edge and `cpuClk` follows the synchronised crystal level, whatever the ratio settings.
- R9: A ratio change takes effect only after the output period in progress completes with its old length.
- R10: With output select 1 and a ratio of D, `cpuClk` is high for ceil(D/2) of every D source ticks. `cpuEn` is a single PLL cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL clock; clocks all block logic |
| rstN | input | 1 | Active-low synchronous reset |
| xtalClk | input | 1 | Crystal reference clock, sampled in the PLL domain |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| cpuEn | output | 1 | One-cycle pulse at the end of each output period |
| cpuClk | output | 1 | Registered CPU clock level |

## Verification
The assertions assume that the crystal is much slower than the PLL clock, so that every crystal level lasts several PLL cycles and the synchroniser never drops an edge. They also assume that no register write arrives while reset is asserted. The bench drives the crystal as a square wave of eight PLL cycles and changes it only on falling PLL edges. Register writes come from tasks after reset has been released. The random settings keep N small when the crystal is the source, so every period completes well within the run.

// File: rtl/cpu_clk_div_pkg.sv
package cpu_clk_div_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int N_W    = 9;
  localparam int DIV_W  = N_W + 1;          // holds 2*N up to 1022
  localparam int RATIO_W = 2;

  localparam logic [ADDR_W-1:0] MAIN_OFF = 8'h40;
  localparam logic [ADDR_W-1:0] AUX_OFF  = 8'h00;

  localparam int SRC_BIT   = 0;
  localparam int RATIO_LSB = 2;
  localparam int OUT_BIT   = 7;
  localparam int N_LSB     = 20;

  localparam logic [DATA_W-1:0] MAIN_MASK =
    (DATA_W'(1) << SRC_BIT) | (DATA_W'((1 << RATIO_W) - 1) << RATIO_LSB) | (DATA_W'(1) << OUT_BIT);
  localparam logic [DATA_W-1:0] AUX_MASK = DATA_W'((1 << N_W) - 1) << N_LSB;

  // strobes and settings handed from control to datapath
  typedef struct packed {
    logic             tick;       // one source tick this cycle
    logic             xtalTick;   // crystal rising edge seen this cycle
    logic             xtalLevel;  // synchronised crystal level
    logic             outSel;     // 1: divided path, 0: crystal pass-through
    logic [DIV_W-1:0] reqDiv;     // requested ratio, never zero
  } ctl_bus_t;
endpackage

// File: rtl/cpu_clk_div_ctl.sv
module cpu_clk_div_ctl
  import cpu_clk_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xtalClk,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output ctl_bus_t          ctlBus
);
  logic               srcSelQ;
  logic               outSelQ;
  logic [RATIO_W-1:0] ratioQ;
  logic [N_W-1:0]     nQ;
  logic [SYNC_STAGES:0] syncQ;   // last stage only feeds edge detection
  logic               unusedWrBits;

  assign unusedWrBits = ^(regWrData & ~(MAIN_MASK | AUX_MASK));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSelQ <= 1'b0;
      outSelQ <= 1'b0;
      ratioQ  <= '0;
      nQ      <= '0;
    end else if (regWrEn) begin
      if (regAddr == MAIN_OFF) begin
        srcSelQ <= regWrData[SRC_BIT];
        ratioQ  <= regWrData[RATIO_LSB +: RATIO_W];
        outSelQ <= regWrData[OUT_BIT];
      end
      if (regAddr == AUX_OFF) begin
        nQ <= regWrData[N_LSB +: N_W];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == MAIN_OFF) begin
      regRdData[SRC_BIT]                 = srcSelQ;
      regRdData[RATIO_LSB +: RATIO_W]    = ratioQ;
      regRdData[OUT_BIT]                 = outSelQ;
    end else if (regAddr == AUX_OFF) begin
      regRdData[N_LSB +: N_W] = nQ;
    end
  end

  // crystal synchroniser, one stage per generate step
  for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else if (i == 0) syncQ[i] <= xtalClk;
      else syncQ[i] <= syncQ[(i == 0) ? 0 : i - 1];
    end
  end

  function automatic logic [DIV_W-1:0] decodeDiv(input logic [RATIO_W-1:0] code,
                                                  input logic [N_W-1:0] n);
    if (code != '1)      return DIV_W'(code) + DIV_W'(1);
    else if (n == '0)    return DIV_W'(1);
    else                 return {n, 1'b0};
  endfunction

  always_comb begin
    ctlBus.xtalLevel = syncQ[SYNC_STAGES-1];
    ctlBus.xtalTick  = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];
    ctlBus.tick      = srcSelQ ? 1'b1 : ctlBus.xtalTick;
    ctlBus.outSel    = outSelQ;
    ctlBus.reqDiv    = decodeDiv(ratioQ, nQ);
  end
endmodule

// File: rtl/cpu_clk_div_dp.sv
module cpu_clk_div_dp
  import cpu_clk_div_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  ctl_bus_t ctlBus,
  output logic     cpuEn,
  output logic     cpuClk
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] activeDiv;
  logic [DIV_W-1:0] cntNext;
  logic [DIV_W-1:0] divNext;
  logic             lastTick;
  logic             periodEnd;
  logic             phaseNext;

  function automatic logic [DIV_W:0] halfUp(input logic [DIV_W-1:0] d);
    return ({1'b0, d} + (DIV_W+1)'(1)) >> 1;
  endfunction

  always_comb begin
    lastTick  = (cnt == activeDiv - DIV_W'(1));
    periodEnd = ctlBus.tick & lastTick;
    cntNext   = cnt;
    divNext   = activeDiv;
    if (periodEnd) begin
      cntNext = '0;
      divNext = ctlBus.reqDiv;   // ratio swaps only at a period boundary
    end else if (ctlBus.tick) begin
      cntNext = cnt + DIV_W'(1);
    end
    phaseNext = ({1'b0, cntNext} < halfUp(divNext));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      activeDiv <= DIV_W'(1);
      cpuEn     <= 1'b0;
      cpuClk    <= 1'b0;
    end else begin
      cnt       <= cntNext;
      activeDiv <= divNext;
      cpuEn     <= ctlBus.outSel ? periodEnd : ctlBus.xtalTick;
      cpuClk    <= ctlBus.outSel ? phaseNext : ctlBus.xtalLevel;
    end
  end
endmodule

// File: rtl/cpu_clk_divider.sv
module cpu_clk_divider
  import cpu_clk_div_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xtalClk,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              cpuEn,
  output logic              cpuClk
);
  ctl_bus_t ctlBus;

  cpu_clk_div_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .xtalClk(xtalClk),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .ctlBus(ctlBus)
  );

  cpu_clk_div_dp u_dp (
    .clk(clk), .rstN(rstN), .ctlBus(ctlBus),
    .cpuEn(cpuEn), .cpuClk(cpuClk)
  );
endmodule

// File: rtl/cpu_clk_div_chk.sv
module cpu_clk_div_chk
  import cpu_clk_div_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              cpuEn,
  input logic              outSel,
  input logic [DIV_W-1:0]  activeDiv,
  input logic [DIV_W-1:0]  cnt
);
  // R2: unmapped bits of the main word stay zero
  a_r2_main_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == MAIN_OFF) |-> ((regRdData & ~MAIN_MASK) == '0));

  // R3: unmapped bits of the auxiliary word stay zero
  a_r3_aux_unused_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == AUX_OFF) |-> ((regRdData & ~AUX_MASK) == '0));

  // R2: a main-word write is visible on the next read
  a_r2_main_readback: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == MAIN_OFF) |=>
      (regAddr != MAIN_OFF || regRdData == ($past(regWrData) & MAIN_MASK)));

  // R9: the working ratio moves only together with an end-of-period pulse
  a_r9_ratio_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeDiv) && $past(outSel)) |-> cpuEn);

  // R6: the working ratio is never zero
  a_r6_div_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    activeDiv != '0);

  // R9: the period counter never passes the working ratio
  a_r9_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cnt < activeDiv);
endmodule

bind cpu_clk_divider cpu_clk_div_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .cpuEn(cpuEn),
  .outSel(ctlBus.outSel), .activeDiv(u_dp.activeDiv), .cnt(u_dp.cnt)
);

// File: tb/cpu_clk_divider_tb.sv
module cpu_clk_divider_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xtalClk = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cpuEn;
  logic        cpuClk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  localparam int XTAL_P = 8;

  cpu_clk_divider u_dut (
    .clk(clk), .rstN(rstN), .xtalClk(xtalClk), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cpuEn(cpuEn), .cpuClk(cpuClk)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (XTAL_P / 2) @(negedge clk);
      xtalClk = ~xtalClk;
    end
  end

  function automatic int expDiv(int sel, int n);
    if (sel < 3) return sel + 1;
    if (n == 0) return 1;
    return 2 * n;
  endfunction

  function automatic logic [31:0] mainVal(bit src, int sel, bit outS);
    return 32'(src) | (32'(sel) << 2) | (32'(outS) << 7);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitStrobe();
    int k = 0;
    do begin @(negedge clk); k++; end while (!cpuEn && k < 20000);
  endtask

  task automatic interval(output int n);
    waitStrobe();
    n = 0;
    do begin @(negedge clk); n++; end while (!cpuEn && n < 20000);
  endtask

  task automatic highsOver(int d, output int h);
    h = 0;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      if (cpuClk) h++;
    end
  endtask

  task automatic settle();
    repeat (3) waitStrobe();
  endtask

  // program a setting and check period and duty on the PLL source
  task automatic pllCase(int sel, int n, string tag);
    int d, got, h;
    d = expDiv(sel, n);
    wr(8'h00, 32'(n) << 20);
    wr(8'h40, mainVal(1'b1, sel, 1'b1));
    settle();
    interval(got);
    check(got == d, tag, got, d);
    waitStrobe();
    highsOver(d, h);
    check(h == (d + 1) / 2, "R10 duty", h, (d + 1) / 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int got, h;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rd(8'h40, v); check(v == 0, "R1 main reset", int'(v), 0);
    rd(8'h00, v); check(v == 0, "R1 aux reset", int'(v), 0);
    settle();
    interval(got); check(got == XTAL_P, "R1 crystal pass-through period", got, XTAL_P);

    // R2 / R3: field placement and unused bits
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); check(v == 32'h8D, "R2 main mask", int'(v), 32'h8D);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); check(v == 32'h1FF0_0000, "R3 aux mask", int'(v), 32'h1FF0_0000);
    wr(8'h20, 32'h0);
    rd(8'h20, v); check(v == 0, "R3 other address", int'(v), 0);
    rd(8'h40, v); check(v == 32'h8D, "R3 other address no effect main", int'(v), 32'h8D);
    rd(8'h00, v); check(v == 32'h1FF0_0000, "R3 other address no effect aux", int'(v), 32'h1FF0_0000);
    wr(8'h40, 32'h0000_0004);
    rd(8'h40, v); check(v == 32'h4, "R2 readback", int'(v), 4);

    // R4 direct codes, R5 2N, R6 N=0
    pllCase(0, 0, "R4 code0");
    pllCase(1, 0, "R4 code1");
    pllCase(2, 0, "R4 code2");
    pllCase(3, 5, "R5 N=5");
    pllCase(3, 511, "R5 N=511");
    pllCase(3, 0, "R6 N=0");

    // R7: crystal source through the divider
    wr(8'h40, mainVal(1'b0, 0, 1'b1));
    settle(); interval(got); check(got == XTAL_P, "R7 crystal div1", got, XTAL_P);
    wr(8'h40, mainVal(1'b0, 2, 1'b1));
    settle(); interval(got); check(got == 3 * XTAL_P, "R7 crystal div3", got, 3 * XTAL_P);

    // R8: pass-through ignores the ratio
    wr(8'h00, 32'(7) << 20);
    wr(8'h40, mainVal(1'b1, 3, 1'b0));
    settle(); interval(got); check(got == XTAL_P, "R8 pass-through period", got, XTAL_P);
    highsOver(XTAL_P, h); check(h == XTAL_P / 2, "R8 pass-through level", h, XTAL_P / 2);

    // R9: ratio change waits for the period end (6 -> 2)
    wr(8'h00, 32'(3) << 20);
    wr(8'h40, mainVal(1'b1, 3, 1'b1));
    settle();
    waitStrobe();
    regWrEn = 1'b1; regAddr = 8'h40; regWrData = mainVal(1'b1, 1, 1'b1);
    got = 0;
    do begin @(negedge clk); regWrEn = 1'b0; got++; end while (!cpuEn && got < 100);
    check(got == 6, "R9 old period kept", got, 6);
    got = 0;
    do begin @(negedge clk); got++; end while (!cpuEn && got < 100);
    check(got == 2, "R9 new period", got, 2);

    // random settings, PLL source
    for (int i = 0; i < 12; i++) begin
      int sel, n;
      sel = int'($urandom_range(3, 0));
      n = int'($urandom_range(40, 0));
      pllCase(sel, n, "R4 R5 random");
      rd(8'h40, v);
      check(v == mainVal(1'b1, sel, 1'b1), "R2 random readback", int'(v), int'(mainVal(1'b1, sel, 1'b1)));
    end

    // random settings, crystal source
    for (int i = 0; i < 4; i++) begin
      int sel, n, d;
      sel = int'($urandom_range(3, 0));
      n = int'($urandom_range(3, 0));
      d = expDiv(sel, n);
      wr(8'h00, 32'(n) << 20);
      wr(8'h40, mainVal(1'b0, sel, 1'b1));
      settle(); interval(got);
      check(got == d * XTAL_P, "R7 random crystal", got, d * XTAL_P);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule